// File: doc/BRIEF.md
# Exact-Match Destination Address Filter

This block sits on the receive path of an Ethernet MAC and decides, once per incoming frame, whether the frame is kept. It compares the 48-bit destination address against a bank of programmable exact-match entries. Each entry is loaded through two configuration writes: a 16-bit upper part and a 32-bit lower part. Each entry is switched on by one bit of an enable mask whose bit order is reversed relative to the entry numbering. A promiscuous mode bit accepts every frame whatever the entries hold.

Software normally puts the broadcast address in entry 0 and the station's own address in entry 1. It uses the remaining entries for multicast groups, and it enables a contiguous run of entries starting at entry 0. The receive datapath presents the destination address with a one-cycle strobe at frame start. One clock later the block returns a registered decision: accept or drop, whether an entry matched, and the number of the lowest matching entry.

Top module: `dst_addr_filter`

## Requirements
- R1: While `rst_n` is low at a clock edge, all entries, the enable mask and the promiscuous bit are cleared and `dec_valid`, `dec_accept`, `dec_hit` and `dec_index` are 0. After reset, any frame is therefore dropped.
- R2: A write with `cfg_kind`=0 loads the upper part of entry `cfg_idx`. Address byte 0 (`da[47:40]`, the first byte on the wire) is taken from `cfg_wdata[15:8]` and byte 1 from `cfg_wdata[7:0]`. Bits 31:16 of that write have no effect.
- R3: A write with `cfg_kind`=1 loads the lower part of entry `cfg_idx`. Byte 2 is taken from `cfg_wdata[31:24]`, byte 3 from bits 23:16, byte 4 from bits 15:8 and byte 5 (`da[7:0]`) from bits 7:0. An index of 17 or more changes no entry.
- R4: A write with `cfg_kind`=2 loads the 17-bit enable mask from `cfg_wdata[16:0]`. Entry n is enabled by mask bit (16 − n), so enabling entries 0 to k−1 sets bits 16 down to 17 − k.
- R5: A frame is accepted when an enabled entry equals all 48 destination bits. A difference in any single bit is a miss for that entry.
- R6: `dec_hit` is 1 when at least one enabled entry matches, and `dec_index` gives the lowest-numbered such entry. When nothing matches, `dec_index` is 0.
- R7: A write with `cfg_kind`=3 sets the promiscuous bit from `cfg_wdata[0]`. While that bit is set, every frame is accepted, and `dec_hit` and `dec_index` still report the entry comparison.
- R8: With no entry enabled and the promiscuous bit clear, every frame is dropped with `dec_hit` at 0.
- R9: `dec_valid` is high for exactly the cycle after each cycle in which `da_valid` is high. `dec_accept`, `dec_hit` and `dec_index` keep their value until the next strobe.
- R10: A configuration write made in the same cycle as `da_valid` does not affect that frame's decision; it applies from the next frame on.
- R11: The contents of a disabled entry have no effect on any decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 2 | Write target: 0 entry upper, 1 entry lower, 2 enable mask, 3 mode |
| cfg_idx | input | 5 | Entry number for kinds 0 and 1 |
| cfg_wdata | input | 32 | Configuration write data |
| da_valid | input | 1 | Destination address strobe, one cycle per frame |
| da | input | 48 | Destination address, first wire byte in bits 47:40 |
| dec_valid | output | 1 | Decision strobe, one cycle after `da_valid` |
| dec_accept | output | 1 | Frame accepted |
| dec_hit | output | 1 | An enabled entry matched |
| dec_index | output | 5 | Lowest matching entry number |

## Verification
A frame strobe and a configuration write can land in the same cycle. That write may change an entry, the enable mask or the promiscuous bit, and the decision must reflect the old setting. The bench provokes each of the three write kinds together with `da_valid`. It predicts the decision from the configuration held before that edge, then sends the same address again and expects the new setting to govern. Sweeps over every contiguous enable run, over every single enabled entry, and over every one-bit corruption of an address check the mapping between entries and mask bits and the full-width compare.

// File: rtl/daf_pkg.sv
// Shared constants and the configuration-target encoding for the
// destination address filter. Assumes 48-bit addresses and 32-bit writes.
package daf_pkg;
    localparam int ADDR_W = 48;
    localparam int HI_W   = 16;
    localparam int LO_W   = ADDR_W - HI_W;
    localparam int CFG_W  = 32;

    typedef enum logic [1:0] {
        CFG_ENT_HI  = 2'd0,
        CFG_ENT_LO  = 2'd1,
        CFG_EN_MASK = 2'd2,
        CFG_MODE    = 2'd3
    } cfg_kind_e;
endpackage

// File: rtl/daf_entry_bank.sv
// Storage for the exact-match entries. Each entry holds a 16-bit upper
// part and a 32-bit lower part written separately; the bank presents all
// entries as a flat vector, entry n at bits [n*48 +: 48].
// Assumes an index at or above N_ENTRIES selects no entry.
module daf_entry_bank #(
    parameter int N_ENTRIES = 17,
    parameter int IDX_W     = 5
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                we,
    input  daf_pkg::cfg_kind_e                  kind,
    input  logic [IDX_W-1:0]                    idx,
    input  logic [daf_pkg::CFG_W-1:0]           wdata,
    output logic [N_ENTRIES*daf_pkg::ADDR_W-1:0] ent_flat
);
    import daf_pkg::*;

    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_ent
        logic [HI_W-1:0] hi_q;
        logic [LO_W-1:0] lo_q;
        logic            sel;

        assign sel = we && (idx == IDX_W'(g));

        // Load this entry's upper or lower part when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hi_q <= '0;
                lo_q <= '0;
            end else if (sel) begin
                case (kind)
                    CFG_ENT_HI: hi_q <= wdata[HI_W-1:0];
                    CFG_ENT_LO: lo_q <= wdata[LO_W-1:0];
                    default: ;
                endcase
            end
        end

        assign ent_flat[g*ADDR_W +: ADDR_W] = {hi_q, lo_q};
    end
endmodule

// File: rtl/daf_match_array.sv
// One 48-bit equality comparator per entry, each gated by its enable bit.
// The enable mask is bit-reversed: entry n uses mask bit N_ENTRIES-1-n.
module daf_match_array #(
    parameter int N_ENTRIES = 17
) (
    input  logic [daf_pkg::ADDR_W-1:0]            da,
    input  logic [N_ENTRIES*daf_pkg::ADDR_W-1:0]  ent_flat,
    input  logic [N_ENTRIES-1:0]                  en_mask,
    output logic [N_ENTRIES-1:0]                  hit_vec
);
    import daf_pkg::*;

    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_cmp
        assign hit_vec[g] = en_mask[N_ENTRIES-1-g] &&
                            (ent_flat[g*ADDR_W +: ADDR_W] == da);
    end
endmodule

// File: rtl/daf_prio_pick.sv
// Picks the lowest-numbered set bit of the hit vector; reports 0 when
// no bit is set.
module daf_prio_pick #(
    parameter int N_ENTRIES = 17,
    parameter int IDX_W     = 5
) (
    input  logic [N_ENTRIES-1:0] hit_vec,
    output logic                 any_hit,
    output logic [IDX_W-1:0]     first_idx
);
    // Scan from the top so the lowest set bit wins.
    always_comb begin
        any_hit   = |hit_vec;
        first_idx = '0;
        for (int i = N_ENTRIES - 1; i >= 0; i--) begin
            if (hit_vec[i]) first_idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/dst_addr_filter.sv
// Receive destination address filter. Holds the enable mask and the
// promiscuous bit, compares each strobed address against the entry bank
// and registers the decision one clock later. Configuration written in
// the strobe cycle lands at the same edge, so that frame sees the old
// setting. Assumes N_ENTRIES <= 32 so the mask fits one write.
module dst_addr_filter #(
    parameter int N_ENTRIES = 17,
    parameter int IDX_W     = $clog2(N_ENTRIES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [1:0]           cfg_kind,
    input  logic [IDX_W-1:0]     cfg_idx,
    input  logic [31:0]          cfg_wdata,
    input  logic                 da_valid,
    input  logic [47:0]          da,
    output logic                 dec_valid,
    output logic                 dec_accept,
    output logic                 dec_hit,
    output logic [IDX_W-1:0]     dec_index
);
    import daf_pkg::*;

    cfg_kind_e                      kind;
    logic [N_ENTRIES-1:0]           mask_q;
    logic                           promisc_q;
    logic [N_ENTRIES*ADDR_W-1:0]    ent_flat;
    logic [N_ENTRIES-1:0]           hit_vec;
    logic                           any_hit;
    logic [IDX_W-1:0]               first_idx;

    assign kind = cfg_kind_e'(cfg_kind);

    // Enable mask and mode bit registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q    <= '0;
            promisc_q <= 1'b0;
        end else if (cfg_we) begin
            case (kind)
                CFG_EN_MASK: mask_q    <= cfg_wdata[N_ENTRIES-1:0];
                CFG_MODE:    promisc_q <= cfg_wdata[0];
                default: ;
            endcase
        end
    end

    daf_entry_bank #(.N_ENTRIES(N_ENTRIES), .IDX_W(IDX_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .kind     (kind),
        .idx      (cfg_idx),
        .wdata    (cfg_wdata),
        .ent_flat (ent_flat)
    );

    daf_match_array #(.N_ENTRIES(N_ENTRIES)) u_match (
        .da       (da),
        .ent_flat (ent_flat),
        .en_mask  (mask_q),
        .hit_vec  (hit_vec)
    );

    daf_prio_pick #(.N_ENTRIES(N_ENTRIES), .IDX_W(IDX_W)) u_pick (
        .hit_vec   (hit_vec),
        .any_hit   (any_hit),
        .first_idx (first_idx)
    );

    // Register the decision on each address strobe; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid  <= 1'b0;
            dec_accept <= 1'b0;
            dec_hit    <= 1'b0;
            dec_index  <= '0;
        end else begin
            dec_valid <= da_valid;
            if (da_valid) begin
                dec_accept <= promisc_q | any_hit;
                dec_hit    <= any_hit;
                dec_index  <= first_idx;
            end
        end
    end
endmodule

// File: rtl/daf_checker.sv
// Temporal checks on the filter's decision interface and its mode state.
module daf_checker #(
    parameter int N_ENTRIES = 17,
    parameter int IDX_W     = 5
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 da_valid,
    input logic                 dec_valid,
    input logic                 dec_accept,
    input logic                 dec_hit,
    input logic [IDX_W-1:0]     dec_index,
    input logic [N_ENTRIES-1:0] mask_q,
    input logic                 promisc_q
);
    p_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        da_valid |=> dec_valid);

    p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !da_valid |=> !dec_valid);

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !da_valid |=> ($stable(dec_accept) && $stable(dec_hit) && $stable(dec_index)));

    p_promisc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (da_valid && promisc_q) |=> dec_accept);

    p_hit_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_hit) |-> dec_accept);

    p_empty_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (da_valid && (mask_q == '0) && !promisc_q) |=> (!dec_accept && !dec_hit));

    p_index_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_hit) |-> (int'(dec_index) < N_ENTRIES));

    p_miss_index_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !dec_hit) |-> (dec_index == '0));
endmodule

bind dst_addr_filter daf_checker #(.N_ENTRIES(N_ENTRIES), .IDX_W(IDX_W)) u_daf_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .da_valid   (da_valid),
    .dec_valid  (dec_valid),
    .dec_accept (dec_accept),
    .dec_hit    (dec_hit),
    .dec_index  (dec_index),
    .mask_q     (mask_q),
    .promisc_q  (promisc_q)
);

// File: tb/tb_dst_addr_filter.sv
module tb_dst_addr_filter;
    localparam int N  = 17;
    localparam int IW = 5;
    localparam logic [47:0] MISS = 48'h01_00_5E_7F_00_00;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_kind = '0;
    logic [IW-1:0] cfg_idx = '0;
    logic [31:0]   cfg_wdata = '0;
    logic          da_valid = 1'b0;
    logic [47:0]   da = '0;
    logic          dec_valid, dec_accept, dec_hit;
    logic [IW-1:0] dec_index;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    logic [15:0] m_hi [N];
    logic [31:0] m_lo [N];
    logic [N-1:0] m_mask = '0;
    logic         m_prom = 1'b0;

    always #2 clk = ~clk;

    dst_addr_filter #(.N_ENTRIES(N)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
        .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .da_valid(da_valid), .da(da),
        .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_hit(dec_hit),
        .dec_index(dec_index)
    );

    function automatic logic [47:0] ent_addr(input int n);
        if (n == 0) return 48'hFFFF_FFFF_FFFF;
        if (n == 1) return 48'h02_12_34_56_78_9A;
        return {8'h01, 8'h00, 8'h5E, 8'h00, 8'(n), 8'(n * 7 + 1)};
    endfunction

    function automatic logic [N-1:0] first_k(input int k);
        logic [N-1:0] m = '0;
        for (int i = 0; i < k; i++) m[N-1-i] = 1'b1;
        return m;
    endfunction

    // Expected decision from the requirement text, using the bench's own state.
    task automatic predict(input logic [47:0] a, output logic acc, output logic hit,
                           output logic [IW-1:0] idx);
        hit = 1'b0; idx = '0;
        for (int n = 0; n < N; n++) begin
            if (!hit && m_mask[N-1-n] && ({m_hi[n], m_lo[n]} == a)) begin
                hit = 1'b1; idx = IW'(n);
            end
        end
        acc = hit | m_prom;
    endtask

    task automatic apply_model(input logic [1:0] k, input int idx, input logic [31:0] d);
        case (k)
            2'd0: if (idx < N) m_hi[idx] = d[15:0];
            2'd1: if (idx < N) m_lo[idx] = d;
            2'd2: m_mask = d[N-1:0];
            default: m_prom = d[0];
        endcase
    endtask

    task automatic check(input string req, input bit ok, input string act, input string exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %s expected %s", req, act, exp);
        end
    endtask

    task automatic check_dec(input string req, input logic ea, input logic eh,
                             input logic [IW-1:0] ei);
        check(req, dec_valid && dec_accept == ea && dec_hit == eh && dec_index == ei,
              $sformatf("v=%0b acc=%0b hit=%0b idx=%0d", dec_valid, dec_accept, dec_hit, dec_index),
              $sformatf("v=1 acc=%0b hit=%0b idx=%0d", ea, eh, ei));
    endtask

    task automatic cfg_write(input logic [1:0] k, input int idx, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_kind = k; cfg_idx = IW'(idx); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        apply_model(k, idx, d);
    endtask

    task automatic send(input logic [47:0] a, input string req);
        logic ea, eh; logic [IW-1:0] ei;
        predict(a, ea, eh, ei);
        @(negedge clk);
        da = a; da_valid = 1'b1;
        @(negedge clk);
        da_valid = 1'b0;
        check_dec(req, ea, eh, ei);
    endtask

    // Frame strobe and configuration write in the same cycle.
    task automatic send_with_write(input logic [47:0] a, input logic [1:0] k,
                                   input int idx, input logic [31:0] d, input string req);
        logic ea, eh; logic [IW-1:0] ei;
        predict(a, ea, eh, ei);
        @(negedge clk);
        da = a; da_valid = 1'b1;
        cfg_we = 1'b1; cfg_kind = k; cfg_idx = IW'(idx); cfg_wdata = d;
        @(negedge clk);
        da_valid = 1'b0; cfg_we = 1'b0;
        check_dec(req, ea, eh, ei);
        apply_model(k, idx, d);
    endtask

    task automatic load_entry(input int n, input logic [47:0] a);
        cfg_write(2'd0, n, {16'hA5C3, a[47:32]});
        cfg_write(2'd1, n, a[31:0]);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic a0, h0; logic [IW-1:0] i0;
        for (int n = 0; n < N; n++) begin m_hi[n] = '0; m_lo[n] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1", !dec_valid && !dec_accept && !dec_hit && dec_index == '0,
              $sformatf("%0b%0b%0b %0d", dec_valid, dec_accept, dec_hit, dec_index), "000 0");
        send(ent_addr(0), "R1");
        send(MISS, "R8");

        // R2 R3: load every entry, upper writes carry junk in bits 31:16
        for (int n = 0; n < N; n++) load_entry(n, ent_addr(n));
        cfg_write(2'd1, 20, 32'h1111_1111);  // R3: index out of range

        // R4 R5: contiguous enable runs
        for (int k = 0; k <= N; k++) begin
            cfg_write(2'd2, 0, 32'(first_k(k)));
            for (int n = 0; n < N; n++) send(ent_addr(n), "R4");
            send(MISS, "R5");
        end

        // R11 R4: one entry enabled at a time
        for (int e = 0; e < N; e++) begin
            cfg_write(2'd2, 0, 32'(1) << (N - 1 - e));
            for (int n = 0; n < N; n++) send(ent_addr(n), "R11");
        end

        // R5: every single-bit corruption of one entry
        cfg_write(2'd2, 0, 32'(first_k(N)));
        send(ent_addr(5), "R5");
        for (int b = 0; b < 48; b++) send(ent_addr(5) ^ (48'd1 << b), "R5");

        // R2 R3: explicit byte placement
        cfg_write(2'd0, 16, 32'hFFFF_1122);
        cfg_write(2'd1, 16, 32'h3344_5566);
        send(48'h1122_3344_5566, "R2");
        send(48'h6655_4433_2211, "R3");

        // R6: duplicate entries, lowest wins
        load_entry(3, 48'h0A0B_0C0D_0E0F);
        load_entry(9, 48'h0A0B_0C0D_0E0F);
        send(48'h0A0B_0C0D_0E0F, "R6");
        cfg_write(2'd2, 0, 32'(first_k(N)) & ~(32'(1) << (N - 1 - 3)));
        send(48'h0A0B_0C0D_0E0F, "R6");

        // R9: outputs hold after the strobe cycle
        a0 = dec_accept; h0 = dec_hit; i0 = dec_index;
        @(negedge clk);
        check("R9", !dec_valid && dec_accept == a0 && dec_hit == h0 && dec_index == i0,
              $sformatf("v=%0b acc=%0b", dec_valid, dec_accept), $sformatf("v=0 acc=%0b", a0));

        // R7: promiscuous mode
        cfg_write(2'd3, 0, 32'h1);
        send(MISS, "R7");
        send(ent_addr(0), "R7");
        cfg_write(2'd3, 0, 32'h0);
        send(MISS, "R7");

        // R10: writes coinciding with the strobe
        cfg_write(2'd2, 0, 32'(first_k(N)));
        send_with_write(ent_addr(7), 2'd1, 7, 32'h0, "R10");
        send(ent_addr(7), "R10");
        send_with_write(MISS, 2'd3, 0, 32'h1, "R10");
        send(MISS, "R10");
        cfg_write(2'd3, 0, 32'h0);
        send_with_write(ent_addr(0), 2'd2, 0, 32'h0, "R10");

        // R8: nothing enabled, promiscuous off
        for (int n = 0; n < N; n++) send(ent_addr(n), "R8");

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule